// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and a 128K x 8 asynchronous static RAM. It takes one read or write at a time over a request/ready handshake and turns it into a strobe sequence that meets the RAM's minimum pulse widths and setup times. The RAM has two chip enables of opposite polarity, an output enable and a write enable. Every phase length is a whole number of clock cycles. The block works each length out at elaboration from a clock-period parameter and the RAM's timing figures in nanoseconds.

A read holds the chip selected with the output enable low until the address access time has passed. The controller then samples the data bus and returns the byte to the host with a one-cycle valid pulse. A write has three parts: one setup cycle with the address and the chip selected, a write-enable pulse, and one hold cycle. The write-enable pulse ends the write. The output enable stays high for the whole write. The controller's data drivers turn on only after the RAM's bus-release time has passed, and they stay on through the hold cycle. The data bus leaves the block as separate output, output-enable and input signals, for a pad ring to combine.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted, the block holds the following outputs: `req_ready` high, `mem_ce1_n` high, `mem_ce2` low, `mem_oe_n` high, `mem_we_n` high, `mem_dq_oe` low, `rsp_valid` low and `rsp_rdata` zero.
- R2: `mem_ce1_n` is always the inverse of `mem_ce2`. The chip is selected (`mem_ce1_n`=0, `mem_ce2`=1) only while an access is in progress.
- R3: A read drives `mem_oe_n` low with `mem_we_n` high for exactly RD_CYC cycles. During that time the chip stays selected and `mem_addr` does not change. RD_CYC is the largest of ceil(tRC/T), ceil(tAA/T) and ceil(tOE/T), where T is the clock period. The defaults give 4.
- R4: A write has three parts, in this order:
  - one setup cycle with the address valid and the chip selected;
  - `mem_we_n` low for exactly WP_CYC cycles, with the chip selected and `mem_oe_n` high;
  - one cycle with `mem_we_n` high and the chip still selected.
  The address stays valid at least tAW before `mem_we_n` rises. WP_CYC is the largest of ceil(tWP/T), ceil(tHZ/T)+ceil(tDS/T), ceil(tAW/T)-1 and ceil(tWC/T)-2. The defaults give 4. From the accepting edge, `req_ready` returns high WP_CYC+3 cycles later.
- R5: `mem_dq_oe` rises DRV_DLY = ceil(tHZ/T) cycles after `mem_we_n` falls, which is 2 at the defaults. It stays high through the cycle in which `mem_we_n` rises. During that time `mem_dq_o` holds the write byte unchanged.
- R6: `mem_dq_oe` is never high while the RAM may still be driving the bus. That means not while the chip is selected with `mem_oe_n` low, and not within tHZ of the RAM ending such a read.
- R7: On a read, `rsp_valid` goes high for exactly one cycle, RD_CYC+1 cycles after the accepting edge. In that cycle `rsp_rdata` carries the byte sampled at the end of the read. A write never raises `rsp_valid`.
- R8: `req_ready` is high only while the block is idle. A request is taken at a clock edge where `req_valid` and `req_ready` are both high. A request presented while `req_ready` is low has no effect on the memory.
- R9: Between two accesses there is at least one cycle with the chip deselected and `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse marking returned read data |
| rsp_rdata | output | 8 | Returned read byte |
| mem_addr | output | 17 | RAM address |
| mem_ce1_n | output | 1 | RAM chip enable, active low |
| mem_ce2 | output | 1 | RAM chip enable, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_o | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data pad drivers |
| mem_dq_i | input | 8 | Data read from the RAM pads |

## Verification
The hardest case to reach from the ports is a write that closely follows a read, while the RAM may still be releasing the bus after its output enable rises. The timing margins of every write-enable pulse are just as hard to see from the ports. The bench attaches a behavioural RAM model and counts, in clock periods, how long the address, select, output enable and write enable have each been stable. From those counts the model returns corrupted data if a read ends too early. It also flags any write pulse, data setup or bus-release window that falls short. The bench then writes and reads back every byte of a 256-address window, interleaves reads with writes, and sends a request while the controller is busy to show that the request is ignored.

// File: rtl/srmc_pkg.sv
`timescale 1ns/1ps
package srmc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WSETUP = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WHOLD  = 3'd4
    } srmc_state_e;

    // whole clock cycles needed to cover a time in ns
    function automatic int unsigned cycles_for(input int unsigned ns, input int unsigned period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/srmc_phase_timer.sv
`timescale 1ns/1ps
module srmc_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] remain
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign remain = cnt_q;
endmodule

// File: rtl/srmc_read_capture.sv
`timescale 1ns/1ps
module srmc_read_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              valid
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.vld  = capture;
        if (capture) cap_d.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign dout  = cap_q.data;
    assign valid = cap_q.vld;
endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
    import srmc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 17,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned CLK_NS  = 20,
    parameter int unsigned T_RC_NS = 70,
    parameter int unsigned T_AA_NS = 70,
    parameter int unsigned T_OE_NS = 35,
    parameter int unsigned T_WC_NS = 70,
    parameter int unsigned T_WP_NS = 50,
    parameter int unsigned T_AW_NS = 60,
    parameter int unsigned T_DS_NS = 30,
    parameter int unsigned T_HZ_NS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    // phase lengths in cycles
    localparam int unsigned RD_CYC  = umax(umax(cycles_for(T_RC_NS, CLK_NS), cycles_for(T_AA_NS, CLK_NS)),
                                           umax(cycles_for(T_OE_NS, CLK_NS), 1));
    localparam int unsigned DRV_DLY = cycles_for(T_HZ_NS, CLK_NS);
    localparam int unsigned AW_C    = cycles_for(T_AW_NS, CLK_NS);
    localparam int unsigned WC_C    = cycles_for(T_WC_NS, CLK_NS);
    localparam int unsigned WP_CYC  = umax(umax(cycles_for(T_WP_NS, CLK_NS), DRV_DLY + cycles_for(T_DS_NS, CLK_NS)),
                                           umax((AW_C > 1) ? AW_C - 1 : 1, (WC_C > 2) ? WC_C - 2 : 1));
    localparam int unsigned CNT_MAX = umax(RD_CYC, WP_CYC);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        srmc_state_e       st;
        logic              sel;
        logic              oe_n;
        logic              we_n;
        logic              drv;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ctrl_t;

    ctrl_t            r_d, r_q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic [CNT_W-1:0] t_remain;
    logic [CNT_W-1:0] nxt_idx;
    logic             cap;
    logic             last_cyc;

    assign last_cyc = (t_remain == CNT_W'(1));
    assign nxt_idx  = CNT_W'(WP_CYC) - t_remain + CNT_W'(1);

    always_comb begin
        r_d    = r_q;
        t_load = 1'b0;
        t_val  = CNT_W'(RD_CYC);
        cap    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                r_d.sel  = 1'b0;
                r_d.oe_n = 1'b1;
                r_d.we_n = 1'b1;
                r_d.drv  = 1'b0;
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.sel   = 1'b1;
                    if (req_write) begin
                        r_d.st = ST_WSETUP;
                    end else begin
                        r_d.st   = ST_READ;
                        r_d.oe_n = 1'b0;
                        t_load   = 1'b1;
                        t_val    = CNT_W'(RD_CYC);
                    end
                end
            end
            ST_READ: begin
                if (last_cyc) begin
                    r_d.st   = ST_IDLE;
                    r_d.sel  = 1'b0;
                    r_d.oe_n = 1'b1;
                    cap      = 1'b1;
                end
            end
            ST_WSETUP: begin
                r_d.st   = ST_WPULSE;
                r_d.we_n = 1'b0;
                r_d.drv  = (DRV_DLY == 0);
                t_load   = 1'b1;
                t_val    = CNT_W'(WP_CYC);
            end
            ST_WPULSE: begin
                if (last_cyc) begin
                    r_d.st   = ST_WHOLD;
                    r_d.we_n = 1'b1;
                    r_d.drv  = 1'b1;
                end else begin
                    r_d.drv  = (nxt_idx >= CNT_W'(DRV_DLY));
                end
            end
            ST_WHOLD: begin
                r_d.st  = ST_IDLE;
                r_d.sel = 1'b0;
                r_d.drv = 1'b0;
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.sel  = 1'b0;
                r_d.oe_n = 1'b1;
                r_d.we_n = 1'b1;
                r_d.drv  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    srmc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .remain   (t_remain)
    );

    srmc_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap),
        .din     (mem_dq_i),
        .dout    (rsp_rdata),
        .valid   (rsp_valid)
    );

    assign req_ready = (r_q.st == ST_IDLE);
    assign mem_addr  = r_q.addr;
    assign mem_ce1_n = ~r_q.sel;
    assign mem_ce2   = r_q.sel;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_we_n  = r_q.we_n;
    assign mem_dq_o  = r_q.wdata;
    assign mem_dq_oe = r_q.drv;

    AST_READ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce1_n && mem_ce2 && mem_we_n)); // R3
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr)); // R3
    AST_WRITE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_oe_n)); // R4
    AST_DRIVE_PAST_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o))); // R5
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_ce1_n)); // R6
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && !mem_ce2 && !mem_dq_oe && mem_we_n)); // R9
endmodule

// File: tb/sram_strobe_ctrl_tb.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_tb;
    localparam int CLK_NS = 20;
    localparam int T_RC = 70, T_AA = 70, T_OE = 35, T_WC = 70;
    localparam int T_WP = 50, T_AW = 60, T_DS = 30, T_HZ = 25;
    localparam logic [8:0] HI = 9'h15A;

    function automatic int cdiv(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int RD_EXP  = 4;  // max(ceil 70/20, ceil 70/20, ceil 35/20)
    localparam int DRV_EXP = 2;  // ceil 25/20
    localparam int WP_EXP  = 4;  // max(3, 2+2, 3-1, 4-2)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_o;
    logic [7:0]  ram_q = 8'h00;

    int n_chk = 0, n_fail = 0, rsp_cnt = 0;
    logic [7:0] mdl_mem [256];
    logic [7:0] ref_mem [256];

    always #(CLK_NS/2) clk = ~clk;

    sram_strobe_ctrl #(
        .ADDR_W(17), .DATA_W(8), .CLK_NS(CLK_NS),
        .T_RC_NS(T_RC), .T_AA_NS(T_AA), .T_OE_NS(T_OE), .T_WC_NS(T_WC),
        .T_WP_NS(T_WP), .T_AW_NS(T_AW), .T_DS_NS(T_DS), .T_HZ_NS(T_HZ)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(ram_q)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // behavioural RAM model, all timing measured in clock periods
    int   addr_stab = 0, sel_run = 0, oe_run = 0, drv_run = 0, we_run = 0, rel = 1000;
    int   p_oe_run = 0, p_drv_run = 0;
    logic [16:0] p_addr = '0;
    logic [7:0]  p_dq_o = '0;
    logic p_we_n = 1'b1, p_oe_n = 1'b1, p_sel = 1'b0, p_ready = 1'b1, p_rsp = 1'b0;
    logic sel, ram_drv;

    always @(negedge clk) begin
        if (rst_n) begin
            sel       = !mem_ce1_n && mem_ce2;
            addr_stab = (mem_addr == p_addr) ? addr_stab + 1 : 1;
            sel_run   = sel ? sel_run + 1 : 0;
            oe_run    = !mem_oe_n ? oe_run + 1 : 0;
            drv_run   = mem_dq_oe ? drv_run + 1 : 0;
            ram_drv   = sel && mem_we_n && !mem_oe_n;
            rel       = ram_drv ? 0 : ((rel < 1000) ? rel + 1 : rel);

            check_eq("R2 enable polarity", int'(mem_ce1_n), int'(!mem_ce2));
            if (mem_dq_oe)
                check_eq("R6 bus released before drive", int'(!ram_drv && rel * CLK_NS >= T_HZ + CLK_NS), 1);
            if (!mem_we_n)
                check_eq("R4 write strobe qualified", int'(sel && mem_oe_n), 1);
            if (!p_we_n && mem_we_n) begin
                check_eq("R4 WE low cycles", we_run, WP_EXP);
                check_eq("R4 WE width ns", int'(we_run * CLK_NS >= T_WP), 1);
                check_eq("R5 data setup cycles", p_drv_run, WP_EXP - DRV_EXP);
                check_eq("R5 drive held past WE rise", int'(mem_dq_oe), 1);
                check_eq("R5 data hold", int'(mem_dq_o), int'(p_dq_o));
                check_eq("R4 address setup to write end", int'((addr_stab - 1) * CLK_NS >= T_AW), 1);
                check_eq("R4 select held at write end", int'(sel), 1);
                check_eq("R4 address high bits", int'(mem_addr[16:8]), int'(HI));
                mdl_mem[p_addr[7:0]] = p_dq_o;
            end
            we_run = !mem_we_n ? we_run + 1 : 0;
            if (mem_dq_oe && !mem_we_n)
                check_eq("R5 drive start after bus release", int'(we_run > DRV_EXP), 1);
            if (!p_oe_n && mem_oe_n)
                check_eq("R3 OE low cycles", p_oe_run, RD_EXP);
            if (!mem_oe_n)
                check_eq("R3 address stable during read", int'(addr_stab >= oe_run), 1);
            if (sel && !p_sel)
                check_eq("R9 idle gap before access", int'(p_ready), 1);
            if (rsp_valid) begin
                rsp_cnt++;
                check_eq("R7 valid is one cycle", int'(p_rsp), 0);
            end
            if (ram_drv && addr_stab * CLK_NS >= T_AA && oe_run * CLK_NS >= T_OE && sel_run * CLK_NS >= T_AA)
                ram_q = mdl_mem[mem_addr[7:0]];
            else
                ram_q = ~mdl_mem[mem_addr[7:0]];
            p_addr = mem_addr; p_we_n = mem_we_n; p_oe_n = mem_oe_n;
            p_oe_run = oe_run; p_drv_run = drv_run; p_dq_o = mem_dq_o;
            p_sel = sel; p_ready = req_ready; p_rsp = rsp_valid;
        end
    end

    task automatic host_access(input logic w, input logic [16:0] a, input logic [7:0] d,
                               output logic [7:0] rd, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (w) begin
            while (!req_ready) begin @(negedge clk); lat++; end
            rd = 8'h00;
        end else begin
            while (!rsp_valid) begin @(negedge clk); lat++; end
            rd = rsp_rdata;
        end
    endtask

    initial begin
        logic [7:0] rd;
        int lat, n_rd;
        n_rd = 0;
        for (int i = 0; i < 256; i++) begin mdl_mem[i] = 8'h00; ref_mem[i] = 8'h00; end
        repeat (4) @(negedge clk);
        // R1 reset state
        check_eq("R1 ready", int'(req_ready), 1);
        check_eq("R1 ce1_n", int'(mem_ce1_n), 1);
        check_eq("R1 ce2", int'(mem_ce2), 0);
        check_eq("R1 oe_n", int'(mem_oe_n), 1);
        check_eq("R1 we_n", int'(mem_we_n), 1);
        check_eq("R1 dq_oe", int'(mem_dq_oe), 0);
        check_eq("R1 rsp_valid", int'(rsp_valid), 0);
        check_eq("R1 rsp_rdata", int'(rsp_rdata), 0);
        rst_n = 1'b1;

        // write sweep over the whole low-byte window
        for (int i = 0; i < 256; i++) begin
            logic [7:0] d;
            d = 8'(i * 29 + 7);
            host_access(1'b1, {HI, 8'(i)}, d, rd, lat);
            ref_mem[i] = d;
            check_eq("R4 write ready latency", lat, WP_EXP + 3);
        end
        check_eq("R7 no valid after writes", rsp_cnt, 0);

        // read sweep
        for (int i = 0; i < 256; i++) begin
            host_access(1'b0, {HI, 8'(i)}, 8'h00, rd, lat);
            n_rd++;
            check_eq("R7 read data", int'(rd), int'(ref_mem[i]));
            check_eq("R7 read latency", lat, RD_EXP + 1);
        end

        // interleaved write/read with inverted data
        for (int i = 0; i < 256; i += 17) begin
            host_access(1'b1, {HI, 8'(i)}, ~ref_mem[i], rd, lat);
            ref_mem[i] = ~ref_mem[i];
            host_access(1'b0, {HI, 8'(i)}, 8'h00, rd, lat);
            n_rd++;
            check_eq("R7 read after write", int'(rd), int'(ref_mem[i]));
        end

        // R8: request during a busy write is ignored
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = {HI, 8'd5}; req_wdata = 8'hA5;
        @(negedge clk);
        ref_mem[5] = 8'hA5;
        req_addr = {HI, 8'd6}; req_wdata = ~ref_mem[6];
        check_eq("R8 ready low while busy", int'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        host_access(1'b0, {HI, 8'd6}, 8'h00, rd, lat);
        n_rd++;
        check_eq("R8 busy request ignored", int'(rd), int'(ref_mem[6]));
        host_access(1'b0, {HI, 8'd5}, 8'h00, rd, lat);
        n_rd++;
        check_eq("R8 accepted write landed", int'(rd), int'(ref_mem[5]));

        repeat (3) @(negedge clk);
        check_eq("R7 valid pulse count", rsp_cnt, n_rd);
        check_eq("R9 idle after traffic", int'(req_ready && mem_ce1_n), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule